// File: doc/BRIEF.md
# Thread Block Dispatcher

This block hands the thread blocks of one launched grid to a set of parallel compute cores. A launch is described by two numbers: how many blocks the grid has and how many threads each block carries. The dispatcher then issues the blocks one at a time, in rising index order. Each block goes whole to exactly one core, and the block's index and thread count travel with it. Cores report finished blocks, and the dispatcher returns that block's slot and threads to the reporting core.

Every core has two separate residency budgets: a number of block slots and a number of thread slots. A block is only placed where both budgets still have room. With small blocks the slot budget runs out first, so part of the thread budget stays idle. With large blocks the thread budget runs out first. The control is a four-state machine. `ST_IDLE` waits for the first launch. `ST_ISSUE` hands out blocks. `ST_DRAIN` waits for the remaining completions once the last block has left. `ST_DONE` reports the finished grid and also accepts the next launch.

The transitions are named as follows. *start* goes from IDLE or DONE to ISSUE on a launch with a non-zero block count. *empty grid* goes from IDLE or DONE to DONE on a launch with zero blocks. *last issued* goes from ISSUE to DRAIN in the cycle the final block index is issued. *all retired* goes from DRAIN to DONE in the cycle the last outstanding completion is accepted.

Top module: `block_dispatcher`

## Requirements
- R1: Every issued block goes to exactly one core and carries the full per-block thread count given at launch on `disp_threads`.
- R2: A core never holds more than `MAX_BLKS` (default 8) resident blocks.
- R3: A core never holds more than `MAX_THR` (default 1536) resident threads.
- R4: A block is issued in a cycle if, and only if, some core has a free block slot and enough free threads for it. Otherwise issuing stalls. Example: 64-thread blocks fill 8 slots and only 512 threads per core.
- R5: Block indices are issued as 0, 1, 2, … up to the block count minus one, each exactly once.
- R6: The chosen core is the lowest-numbered core that passes both limits, where `disp_core` is the binary core number.
- R7: A completion returns one slot and one block's threads to its core at the clock edge where it is sampled. A core that was full becomes eligible in the following cycle, not in the completion cycle itself.
- R8: `launch_done` rises in the cycle after the edge that accepts the last outstanding completion. A launch with zero blocks raises it in the cycle after the launch is accepted.
- R9: A launch request seen while the machine is in ISSUE or DRAIN is ignored. The current grid's thread count and block count are unchanged.
- R10: A completion pulse from a core with no resident block is ignored and does not free capacity on that core.
- R11: After reset, `disp_valid` and `launch_done` are both low and no block is issued until a launch arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| launch_valid | input | 1 | Launch request, taken in IDLE or DONE |
| launch_blocks | input | IDX_W | Number of blocks in the grid |
| launch_threads | input | TCNT_W | Threads per block, 1 to MAX_THR |
| cmpl_valid | input | NUM_CORES | One bit per core: that core finished one block this cycle |
| disp_valid | output | 1 | A block is issued this cycle |
| disp_core | output | CORE_W | Binary number of the receiving core |
| disp_blk_idx | output | IDX_W | Index of the issued block |
| disp_threads | output | TCNT_W | Thread count of the issued block |
| launch_done | output | 1 | All blocks of the grid issued and completed |

## Verification
Two things can land in the same cycle: an issue to a core and a completion from that same core. A completion can also arrive from a core that is full in the cycle the picker scans for room. The bench provokes both by sending completion pulses during the issue phase while the cores sit at their block or thread limit. Each cycle it predicts the receiving core from its own residency counts, as they stood before that cycle's edge. So a freed core must not be chosen until the next cycle, and a core that both receives and retires a block must end with an unchanged count.

// File: rtl/blkdisp_pkg.sv
package blkdisp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DRAIN = 2'd2,
        ST_DONE  = 2'd3
    } disp_state_e;

endpackage

// File: rtl/core_slot_tracker.sv
module core_slot_tracker #(
    parameter int MAX_BLKS = 8,
    parameter int MAX_THR  = 1536,
    parameter int BCNT_W   = 4,
    parameter int TCNT_W   = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_i,
    input  logic              cmpl_i,
    input  logic [TCNT_W-1:0] blk_thr_i,
    output logic              fits_o,
    output logic              cmpl_ok_o
);

    logic [BCNT_W-1:0] blk_cnt;
    logic [TCNT_W-1:0] thr_cnt;
    logic [TCNT_W:0]   thr_sum;

    // A completion counts only if the core actually holds a block.
    assign cmpl_ok_o = cmpl_i && (blk_cnt != '0);
    assign thr_sum   = {1'b0, thr_cnt} + {1'b0, blk_thr_i};
    assign fits_o    = (blk_cnt < BCNT_W'(MAX_BLKS)) &&
                       (thr_sum <= (TCNT_W+1)'(MAX_THR));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_cnt <= '0;
            thr_cnt <= '0;
        end else begin
            unique case ({issue_i, cmpl_ok_o})
                2'b10: begin
                    blk_cnt <= blk_cnt + 1'b1;
                    thr_cnt <= thr_cnt + blk_thr_i;
                end
                2'b01: begin
                    blk_cnt <= blk_cnt - 1'b1;
                    thr_cnt <= thr_cnt - blk_thr_i;
                end
                default: begin
                    blk_cnt <= blk_cnt;
                    thr_cnt <= thr_cnt;
                end
            endcase
        end
    end

    // R2: block-slot budget never exceeded
    p_blk_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        blk_cnt <= BCNT_W'(MAX_BLKS));

    // R3: thread budget never exceeded
    p_thr_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        thr_cnt <= TCNT_W'(MAX_THR));

    // R4: the sequencer issues here only when both limits allow it
    p_issue_fit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i |-> fits_o);

    // R7: an accepted completion frees one slot by the next cycle
    p_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_ok_o && !issue_i) |=> (blk_cnt == BCNT_W'($past(blk_cnt) - 1'b1)));

    // R10: a completion on an empty core leaves it empty
    p_empty_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_i && (blk_cnt == '0) && !issue_i) |=> (blk_cnt == '0) && (thr_cnt == '0));

endmodule

// File: rtl/core_picker.sv
module core_picker #(
    parameter int NUM_CORES = 4,
    parameter int CORE_W    = 2
) (
    input  logic [NUM_CORES-1:0] fit_i,
    output logic                 any_o,
    output logic [CORE_W-1:0]    idx_o
);

    // Scan from the top down so the lowest eligible core wins.
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = NUM_CORES - 1; i >= 0; i--) begin
            if (fit_i[i]) begin
                any_o = 1'b1;
                idx_o = CORE_W'(i);
            end
        end
    end

endmodule

// File: rtl/dispatch_fsm.sv
module dispatch_fsm
    import blkdisp_pkg::*;
#(
    parameter int IDX_W  = 16,
    parameter int TCNT_W = 11,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_valid,
    input  logic [IDX_W-1:0]  launch_blocks,
    input  logic [TCNT_W-1:0] launch_threads,
    input  logic              any_fit,
    input  logic [CNT_W-1:0]  cmpl_cnt,
    output logic              issue,
    output logic [IDX_W-1:0]  blk_idx,
    output logic [TCNT_W-1:0] blk_thr,
    output logic              launch_done
);

    disp_state_e       state, state_nxt;
    logic [IDX_W-1:0]  total_q;
    logic [IDX_W-1:0]  nxt_idx_q;
    logic [IDX_W-1:0]  outstanding_q;
    logic [TCNT_W-1:0] thr_q;
    logic              accept;
    logic              last_issue;
    logic              all_retired;

    assign accept      = launch_valid && ((state == ST_IDLE) || (state == ST_DONE));
    assign last_issue  = issue && (nxt_idx_q == total_q - 1'b1);
    assign all_retired = (outstanding_q - IDX_W'(cmpl_cnt)) == '0;

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE, ST_DONE: begin
                if (launch_valid)
                    state_nxt = (launch_blocks == '0) ? ST_DONE : ST_ISSUE;
            end
            ST_ISSUE: begin
                if (last_issue)
                    state_nxt = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (all_retired)
                    state_nxt = ST_DONE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // state register and grid bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= ST_IDLE;
            total_q       <= '0;
            nxt_idx_q     <= '0;
            outstanding_q <= '0;
            thr_q         <= '0;
        end else begin
            state <= state_nxt;
            if (accept) begin
                total_q       <= launch_blocks;
                thr_q         <= launch_threads;
                nxt_idx_q     <= '0;
                outstanding_q <= '0;
            end else begin
                nxt_idx_q     <= nxt_idx_q + IDX_W'(issue);
                outstanding_q <= outstanding_q + IDX_W'(issue) - IDX_W'(cmpl_cnt);
            end
        end
    end

    // outputs
    always_comb begin
        issue       = (state == ST_ISSUE) && any_fit;
        launch_done = (state == ST_DONE);
        blk_idx     = nxt_idx_q;
        blk_thr     = thr_q;
    end

    // R8: the done state is entered only with nothing outstanding
    p_done_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) |-> (outstanding_q == '0) && (nxt_idx_q == total_q));

    // R9: a launch while busy leaves the grid description untouched
    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_valid && ((state == ST_ISSUE) || (state == ST_DRAIN)))
        |=> (thr_q == $past(thr_q)) && (total_q == $past(total_q)));

    // R5: indices never run past the grid
    p_idx_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> (nxt_idx_q < total_q));

endmodule

// File: rtl/block_dispatcher.sv
module block_dispatcher
    import blkdisp_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int MAX_BLKS  = 8,
    parameter int MAX_THR   = 1536,
    parameter int IDX_W     = 16,
    localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    localparam int TCNT_W   = $clog2(MAX_THR + 1),
    localparam int BCNT_W   = $clog2(MAX_BLKS + 1),
    localparam int CNT_W    = $clog2(NUM_CORES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 launch_valid,
    input  logic [IDX_W-1:0]     launch_blocks,
    input  logic [TCNT_W-1:0]    launch_threads,
    input  logic [NUM_CORES-1:0] cmpl_valid,
    output logic                 disp_valid,
    output logic [CORE_W-1:0]    disp_core,
    output logic [IDX_W-1:0]     disp_blk_idx,
    output logic [TCNT_W-1:0]    disp_threads,
    output logic                 launch_done
);

    logic [NUM_CORES-1:0] core_fit;
    logic [NUM_CORES-1:0] core_cmpl_ok;
    logic [NUM_CORES-1:0] core_issue;
    logic                 any_fit;
    logic [CORE_W-1:0]    pick_idx;
    logic [CNT_W-1:0]     cmpl_cnt;
    logic                 issue;
    logic [TCNT_W-1:0]    blk_thr;
    logic                 lower_fit;

    generate
        for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
            assign core_issue[c] = issue && (pick_idx == CORE_W'(c));
            core_slot_tracker #(
                .MAX_BLKS (MAX_BLKS),
                .MAX_THR  (MAX_THR),
                .BCNT_W   (BCNT_W),
                .TCNT_W   (TCNT_W)
            ) u_trk (
                .clk       (clk),
                .rst_n     (rst_n),
                .issue_i   (core_issue[c]),
                .cmpl_i    (cmpl_valid[c]),
                .blk_thr_i (blk_thr),
                .fits_o    (core_fit[c]),
                .cmpl_ok_o (core_cmpl_ok[c])
            );
        end
    endgenerate

    always_comb begin
        cmpl_cnt = '0;
        for (int i = 0; i < NUM_CORES; i++)
            cmpl_cnt = cmpl_cnt + CNT_W'(core_cmpl_ok[i]);
    end

    core_picker #(
        .NUM_CORES (NUM_CORES),
        .CORE_W    (CORE_W)
    ) u_pick (
        .fit_i (core_fit),
        .any_o (any_fit),
        .idx_o (pick_idx)
    );

    dispatch_fsm #(
        .IDX_W  (IDX_W),
        .TCNT_W (TCNT_W),
        .CNT_W  (CNT_W)
    ) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .launch_valid   (launch_valid),
        .launch_blocks  (launch_blocks),
        .launch_threads (launch_threads),
        .any_fit        (any_fit),
        .cmpl_cnt       (cmpl_cnt),
        .issue          (issue),
        .blk_idx        (disp_blk_idx),
        .blk_thr        (blk_thr),
        .launch_done    (launch_done)
    );

    assign disp_valid   = issue;
    assign disp_core    = pick_idx;
    assign disp_threads = blk_thr;

    always_comb begin
        lower_fit = 1'b0;
        for (int i = 0; i < NUM_CORES; i++)
            if ((CORE_W'(i) < pick_idx) && core_fit[i])
                lower_fit = 1'b1;
    end

    // R6: the chosen core has room and no lower core has room
    p_lowest_core_r6: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> core_fit[pick_idx] && !lower_fit);

    // R1: exactly one tracker receives each issued block
    p_whole_block_r1: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> $onehot(core_issue));

endmodule

// File: tb/block_dispatcher_bench.sv
`timescale 1ns/1ps
module block_dispatcher_bench;

    localparam int NC   = 4;
    localparam int MAXB = 8;
    localparam int MAXT = 1536;

    // threads, blocks, expected blocks on core 0 at stall, expected issued at stall
    localparam int NROWS = 7;
    localparam int TBL [NROWS][4] = '{
        '{  64, 40, 8, 32},
        '{ 256, 30, 6, 24},
        '{ 512, 20, 3, 12},
        '{1024,  6, 1,  4},
        '{ 192, 40, 8, 32},
        '{ 100,  3, 3,  3},
        '{1536,  5, 1,  4}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        launch_valid = 1'b0;
    logic [15:0] launch_blocks = '0;
    logic [10:0] launch_threads = '0;
    logic [3:0]  cmpl_valid = '0;
    logic        disp_valid;
    logic [1:0]  disp_core;
    logic [15:0] disp_blk_idx;
    logic [10:0] disp_threads;
    logic        launch_done;

    always #2 clk = ~clk;

    block_dispatcher u_block_dispatcher (
        .clk            (clk),
        .rst_n          (rst_n),
        .launch_valid   (launch_valid),
        .launch_blocks  (launch_blocks),
        .launch_threads (launch_threads),
        .cmpl_valid     (cmpl_valid),
        .disp_valid     (disp_valid),
        .disp_core      (disp_core),
        .disp_blk_idx   (disp_blk_idx),
        .disp_threads   (disp_threads),
        .launch_done    (launch_done)
    );

    int n_chk = 0;
    int n_fail = 0;
    int bcnt [NC];
    int tcnt [NC];
    int cur_total = 0;
    int cur_thr = 0;
    int exp_idx = 0;
    bit launched = 0;
    bit core3_got = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int predict_core();
        for (int c = 0; c < NC; c++)
            if (bcnt[c] < MAXB && tcnt[c] + cur_thr <= MAXT) return c;
        return -1;
    endfunction

    function automatic int resident();
        int s = 0;
        for (int c = 0; c < NC; c++) s += bcnt[c];
        return s;
    endfunction

    // Called at a negedge; ends at the next negedge.
    task automatic cycle(input logic [3:0] cm);
        int  pc;
        bit  active;
        bit  exp_done;
        cmpl_valid = cm;
        #1;
        pc = predict_core();
        active = launched && (exp_idx < cur_total);
        check(disp_valid == (active && pc >= 0), "R4 issue iff room", int'(disp_valid), int'(active && pc >= 0));
        if (disp_valid && active && pc >= 0) begin
            check(int'(disp_core) == pc, "R6 lowest core", int'(disp_core), pc);
            check(int'(disp_blk_idx) == exp_idx, "R5 index order", int'(disp_blk_idx), exp_idx);
            check(int'(disp_threads) == cur_thr, "R1 whole block threads", int'(disp_threads), cur_thr);
        end
        exp_done = launched && (exp_idx == cur_total) && (resident() == 0);
        check(launch_done == exp_done, "R8 launch done", int'(launch_done), int'(exp_done));
        @(posedge clk);
        for (int c = 0; c < NC; c++)
            if (cm[c] && bcnt[c] > 0) begin
                bcnt[c]--;
                tcnt[c] -= cur_thr;
            end
        if (active && pc >= 0) begin
            bcnt[pc]++;
            tcnt[pc] += cur_thr;
            exp_idx++;
            if (pc == 3) core3_got = 1;
        end
        @(negedge clk);
        cmpl_valid = '0;
    endtask

    task automatic launch(input int blocks, input int thr);
        launch_valid   = 1'b1;
        launch_blocks  = 16'(blocks);
        launch_threads = 11'(thr);
        @(posedge clk);
        @(negedge clk);
        launch_valid = 1'b0;
        launched  = 1;
        cur_total = blocks;
        cur_thr   = thr;
        exp_idx   = 0;
        core3_got = 0;
    endtask

    task automatic drain(input bit alt);
        int guard = 0;
        logic [3:0] cm;
        while (!(exp_idx == cur_total && resident() == 0) && guard < 2000) begin
            cm = '0;
            for (int c = 0; c < NC; c++)
                if (bcnt[c] > 0 && (!alt || (c % 2) == (guard % 2))) cm[c] = 1'b1;
            cycle(cm);
            guard++;
        end
        cycle('0);
        check(launch_done == 1'b1, "R8 done after drain", int'(launch_done), 1);
        check(exp_idx == cur_total, "R5 all indices issued", exp_idx, cur_total);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 50000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < NC; c++) begin
            bcnt[c] = 0;
            tcnt[c] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state
        check(disp_valid == 1'b0, "R11 reset disp_valid", int'(disp_valid), 0);
        check(launch_done == 1'b0, "R11 reset launch_done", int'(launch_done), 0);
        cycle('0);
        cycle('0);

        // R8: zero-block grid finishes at once
        launch(0, 64);
        check(launch_done == 1'b1, "R8 empty grid done", int'(launch_done), 1);
        cycle('0);

        // Table walk: fill to the stall point, then drain with completions
        for (int r = 0; r < NROWS; r++) begin
            launch(TBL[r][1], TBL[r][0]);
            for (int k = 0; k < 40; k++) cycle('0);
            check(exp_idx == TBL[r][3], "R4 issued at stall", exp_idx, TBL[r][3]);
            check(bcnt[0] == TBL[r][2], "R2 R3 core0 residency", bcnt[0], TBL[r][2]);
            check(bcnt[0] <= MAXB, "R2 slot cap", bcnt[0], MAXB);
            check(tcnt[0] <= MAXT, "R3 thread cap", tcnt[0], MAXT);
            drain(r % 2 == 1);
        end

        // R7: a full core retires a block while other blocks wait
        launch(10, 1024);
        for (int k = 0; k < 6; k++) cycle('0);
        check(exp_idx == 4, "R7 stall before completion", exp_idx, 4);
        cycle(4'b0010);
        check(exp_idx == 4, "R7 no issue in completion cycle", exp_idx, 4);
        cycle('0);
        check(bcnt[1] == 1 && exp_idx == 5, "R7 freed core refilled next cycle", exp_idx, 5);
        drain(1'b0);

        // R9: launch while busy is ignored
        launch(10, 300);
        cycle('0);
        launch_valid   = 1'b1;
        launch_blocks  = 16'd2;
        launch_threads = 11'd7;
        cycle('0);
        launch_valid = 1'b0;
        cycle('0);
        check(int'(disp_threads) == 300, "R9 threads kept", int'(disp_threads), 300);
        drain(1'b1);
        check(exp_idx == 10, "R9 block count kept", exp_idx, 10);

        // R10: completion from an empty core does not free anything
        launch(4, 1024);
        cycle(4'b1000);
        for (int k = 0; k < 5; k++) cycle('0);
        check(core3_got == 1'b1, "R10 core3 still usable", int'(core3_got), 1);
        check(exp_idx == 4, "R10 all four placed", exp_idx, 4);
        drain(1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule